// File: doc/BRIEF.md
# Four-Lane Poly1305 Chunk Accumulator

This block folds 64-byte chunks of a message into a Poly1305 accumulator. A chunk holds four 16-byte blocks. Each chunk is absorbed in a single update of the form h' = (h + m1)·k4 + m2·k3 + m3·k2 + m4·k1, where k1 is the key r and k2..k4 are its powers r², r³, r⁴. The caller supplies those powers already reduced. The accumulator is a 130-bit value modulo 2^130 − 5. It is held as five limbs in radix 2^26, and each limb is stored in a 32-bit field so that a partly reduced limb still fits.

A caller loads the starting accumulator and a chunk count with `start`. It then hands over one chunk each time `msg_ready` is high, and reads the new accumulator when `done` pulses. All products go through one multiplier, one per cycle: 100 products per chunk, plus one cycle to accept the chunk and one cycle for the carry pass. The carry pass is a partial reduction and runs on 64-bit sums, so carries larger than 32 bits are kept intact.

Top module: `poly4_accum`

## Requirements
- R1: After `start` with a nonzero count N, `msg_ready` goes high once for each of N chunks. A chunk is taken in any cycle where both `msg_valid` and `msg_ready` are high. `msg_ready` is low while the block is idle.
- R2: Byte b of a chunk sits at `msg[8b+7:8b]`, and each 16-byte block is read little-endian. Block m1 is bytes 0..15, m2 is bytes 16..31, m3 is bytes 32..47 and m4 is bytes 48..63. Every block gets 2^128 added. After each chunk, the value of `h_out` modulo 2^130 − 5 equals (h + m1)·k4 + m2·k3 + m3·k2 + m4·k1.
- R3: Key limb j is `key[26j+25:26j]`. Accumulator limb j is `h[32j+31:32j]`, and the accumulator value is the sum of limb j · 2^(26j). `start` loads `h_in` as the starting accumulator.
- R4: Whenever `done` is high, limbs 0, 2, 3 and 4 of `h_out` are below 2^26 and limb 1 is below 2^27.
- R5: A `start` with a count of zero raises `done` in the next cycle, and `h_out` then equals the `h_in` that came with that `start`.
- R6: `done` is high for exactly one cycle after the last chunk is reduced. `busy` is high from the accepted `start` until that cycle and is low while `done` is high.
- R7: `start` has no effect while `busy` is high. While idle without `start`, `h_out` holds its value.
- R8: Results stay correct when every limb of every key power is 2^26 − 1 and every message byte is 0xFF, which is the case that gives the widest carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| chunk_cnt | input | CNT_W | Number of 64-byte chunks to absorb |
| h_in | input | 160 | Starting accumulator, five 32-bit limb fields |
| key_r1 | input | 130 | Key r, five 26-bit limbs |
| key_r2 | input | 130 | r² mod p, five 26-bit limbs |
| key_r3 | input | 130 | r³ mod p, five 26-bit limbs |
| key_r4 | input | 130 | r⁴ mod p, five 26-bit limbs |
| msg | input | 512 | One 64-byte chunk, byte 0 in the low bits |
| msg_valid | input | 1 | Chunk on `msg` is valid |
| msg_ready | output | 1 | Block waits for a chunk |
| h_out | output | 160 | Accumulator, five 32-bit limb fields |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `h_in` limbs have the same bounds the block itself produces (R4) and that key limbs are 26 bits. Under those assumptions no 64-bit lane sum can overflow. The bench only loads values that satisfy this. Starting accumulators are always reduced values below 2^130 split into 26-bit limbs, or the output of an earlier operation. Key powers are reduced residues, or all-maximum limbs for the carry stress case, and they are held steady for the whole operation.

// File: rtl/poly4_accum.sv
module poly4_accum #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] chunk_cnt,
  input  logic [159:0]     h_in,
  input  logic [129:0]     key_r1,
  input  logic [129:0]     key_r2,
  input  logic [129:0]     key_r3,
  input  logic [129:0]     key_r4,
  input  logic [511:0]     msg,
  input  logic             msg_valid,
  output logic             msg_ready,
  output logic [159:0]     h_out,
  output logic             busy,
  output logic             done
);
  localparam int LW    = 26;
  localparam int NLIMB = 5;
  localparam int HW    = 32;
  localparam logic [ACC_W-1:0] LMASK = ACC_W'((64'd1 << LW) - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_MAC, S_RED} st_t;

  st_t                           st_q;
  logic [CNT_W-1:0]              rem_q;
  logic [1:0]                    lane_q;
  logic [2:0]                    oj_q, ii_q;
  logic [511:0]                  msg_q;
  logic [NLIMB-1:0][ACC_W-1:0]   d_q;
  logic [NLIMB-1:0][HW-1:0]      h_q;
  logic                          done_q;

  assign msg_ready = (st_q == S_WAIT);
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign h_out     = h_q;

  // operand A: message limb of the current lane, plus h on lane 0
  logic [31:0]      word;
  logic [HW-1:0]    a_op;
  logic [129:0]     kv;
  logic [2:0]       k_idx;
  logic [LW-1:0]    k_limb;
  logic [LW+2:0]    b_op;
  logic [ACC_W-1:0] prod;

  always_comb begin
    word = msg_q[{lane_q, 7'd0} + 9'(ii_q) * 9'd24 +: 32] >> (5'(ii_q) << 1);
    if (ii_q == 3'd4) a_op = word | 32'h0100_0000;
    else              a_op = word & 32'h03ff_ffff;
    if (lane_q == 2'd0) a_op = a_op + h_q[ii_q];
    case (lane_q)
      2'd0:    kv = key_r4;
      2'd1:    kv = key_r3;
      2'd2:    kv = key_r2;
      default: kv = key_r1;
    endcase
    k_idx  = (ii_q <= oj_q) ? (oj_q - ii_q) : (oj_q + 3'd5 - ii_q);
    k_limb = kv[8'(k_idx) * 8'd26 +: LW];
    b_op   = (ii_q > oj_q) ? (LW+3)'(k_limb) * (LW+3)'(5) : (LW+3)'(k_limb);
    prod   = ACC_W'(a_op) * ACC_W'(b_op);
  end

  // partial reduction d0->d1->d2->d3->d4->d0->d1 on wide sums
  logic [ACC_W-1:0] t1, t2, t3, t4, h0b;
  logic [NLIMB-1:0][HW-1:0] h_red;

  always_comb begin
    t1  = d_q[1] + (d_q[0] >> LW);
    t2  = d_q[2] + (t1 >> LW);
    t3  = d_q[3] + (t2 >> LW);
    t4  = d_q[4] + (t3 >> LW);
    h0b = (d_q[0] & LMASK) + (t4 >> LW) * ACC_W'(5);
    h_red[0] = HW'(h0b & LMASK);
    h_red[1] = HW'(t1 & LMASK) + HW'(h0b >> LW);
    h_red[2] = HW'(t2 & LMASK);
    h_red[3] = HW'(t3 & LMASK);
    h_red[4] = HW'(t4 & LMASK);
  end

  wire mac_last = (lane_q == 2'd3) && (oj_q == 3'd4) && (ii_q == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      lane_q <= '0;
      oj_q   <= '0;
      ii_q   <= '0;
      msg_q  <= '0;
      d_q    <= '0;
      h_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          h_q   <= h_in;
          rem_q <= chunk_cnt;
          if (chunk_cnt == '0) done_q <= 1'b1;
          else                 st_q   <= S_WAIT;
        end
        S_WAIT: if (msg_valid) begin
          msg_q  <= msg;
          d_q    <= '0;
          lane_q <= '0;
          oj_q   <= '0;
          ii_q   <= '0;
          st_q   <= S_MAC;
        end
        S_MAC: begin
          d_q[oj_q] <= d_q[oj_q] + prod;
          if (ii_q != 3'd4) ii_q <= ii_q + 3'd1;
          else begin
            ii_q <= '0;
            if (oj_q != 3'd4) oj_q <= oj_q + 3'd1;
            else begin
              oj_q   <= '0;
              lane_q <= lane_q + 2'd1;
            end
          end
          if (mac_last) st_q <= S_RED;
        end
        default: begin
          h_q   <= h_red;
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            st_q <= S_WAIT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/poly4_accum_chk.sv
module poly4_accum_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] chunk_cnt,
  input logic [159:0]     h_in,
  input logic [159:0]     h_out,
  input logic             msg_ready,
  input logic             busy,
  input logic             done
);
  a_r4_limbs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (h_out[31:26] == 0) && (h_out[63:59] == 0) && (h_out[95:90] == 0)
             && (h_out[127:122] == 0) && (h_out[159:154] == 0));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r1_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> busy);

  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && chunk_cnt == '0) |=> (done && h_out == $past(h_in)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(h_out));
endmodule

bind poly4_accum poly4_accum_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .chunk_cnt(chunk_cnt),
  .h_in(h_in), .h_out(h_out), .msg_ready(msg_ready), .busy(busy), .done(done)
);

// File: tb/poly4_accum_tb.sv
`timescale 1ns/1ps
module poly4_accum_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   chunk_cnt = '0;
  logic [159:0] h_in = '0;
  logic [129:0] key_r1 = '0, key_r2 = '0, key_r3 = '0, key_r4 = '0;
  logic [511:0] msg = '0;
  logic         msg_valid = 1'b0;
  logic         msg_ready, busy, done;
  logic [159:0] h_out;

  int checks = 0;
  int errors = 0;
  logic [511:0] mbuf [4];

  always #10 clk = ~clk;

  poly4_accum dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chunk_cnt(chunk_cnt), .h_in(h_in),
    .key_r1(key_r1), .key_r2(key_r2), .key_r3(key_r3), .key_r4(key_r4),
    .msg(msg), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .h_out(h_out), .busy(busy), .done(done)
  );

  function automatic logic [129:0] pmod();
    return {130{1'b1}} - 130'd4;
  endfunction

  function automatic logic [129:0] fold(input logic [261:0] x);
    logic [261:0] y = x;
    for (int k = 0; k < 4; k++) y = {132'd0, y[129:0]} + (y >> 130) * 262'd5;
    for (int k = 0; k < 2; k++) if (y >= {132'd0, pmod()}) y = y - {132'd0, pmod()};
    return y[129:0];
  endfunction

  function automatic logic [129:0] mulmod(input logic [129:0] a, input logic [129:0] b);
    return fold(262'(a) * 262'(b));
  endfunction

  function automatic logic [129:0] blk(input logic [511:0] m, input int l);
    return fold(262'(m[128*l +: 128]) + (262'd1 << 128));
  endfunction

  function automatic logic [159:0] to_h(input logic [129:0] v);
    logic [159:0] r = '0;
    for (int k = 0; k < 5; k++) r[32*k +: 32] = 32'(v[26*k +: 26]);
    return r;
  endfunction

  function automatic logic [129:0] h_val(input logic [159:0] h);
    logic [261:0] v = '0;
    for (int k = 0; k < 5; k++) v = v + (262'(h[32*k +: 32]) << (26*k));
    return fold(v);
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-chunk model; chained: one multiply per block (keys consistent),
  // otherwise the four-power chunk formula with the given powers
  function automatic logic [129:0] model(input logic [129:0] h, input logic [511:0] m, input bit chained);
    logic [129:0] acc = h;
    if (chained) begin
      for (int l = 0; l < 4; l++) acc = mulmod(fold(262'(acc) + 262'(blk(m, l))), key_r1);
    end else begin
      acc = fold(262'(mulmod(fold(262'(h) + 262'(blk(m, 0))), key_r4))
               + 262'(mulmod(blk(m, 1), key_r3))
               + 262'(mulmod(blk(m, 2), key_r2))
               + 262'(mulmod(blk(m, 3), key_r1)));
    end
    return acc;
  endfunction

  task automatic run_op(input logic [129:0] hs, input int n, input bit chained,
                        input bit poke_start, output logic [129:0] hres);
    logic [129:0] exp = hs;
    int dones = 0;
    int to;
    for (int c = 0; c < n; c++) exp = model(exp, mbuf[c], chained);
    @(negedge clk);
    h_in = to_h(hs); chunk_cnt = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check(done === 1'b1, "R5 done", {159'd0, done}, 160'd1);
      check(h_out === to_h(hs), "R5 hold", h_out, to_h(hs));
      @(negedge clk);
      check(done === 1'b0, "R6 pulse", {159'd0, done}, 160'd0);
      hres = hs;
      return;
    end
    check(busy === 1'b1, "R6 busy", {159'd0, busy}, 160'd1);
    for (int c = 0; c < n; c++) begin
      to = 0;
      while (msg_ready !== 1'b1 && to < 500) begin
        if (done) dones++;
        @(negedge clk); to++;
      end
      check(msg_ready === 1'b1, "R1 ready", {159'd0, msg_ready}, 160'd1);
      msg = mbuf[c]; msg_valid = 1'b1;
      @(negedge clk);
      msg_valid = 1'b0; msg = '0;
      if (poke_start && c == 0) begin
        h_in = '0; chunk_cnt = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b0, "R7 start ignored", {159'd0, done}, 160'd0);
      end
    end
    to = 0;
    while (done !== 1'b1 && to < 500) begin
      @(negedge clk); to++;
    end
    check(done === 1'b1 && dones == 0, "R6 done", {159'd0, done}, 160'd1);
    check(busy === 1'b0, "R6 busy low", {159'd0, busy}, 160'd0);
    check(h_val(h_out) == exp, chained ? "R2 value" : "R8 value", {30'd0, h_val(h_out)}, {30'd0, exp});
    check(h_out[31:26] == 0 && h_out[63:59] == 0 && h_out[95:90] == 0 &&
          h_out[127:122] == 0 && h_out[159:154] == 0, "R4 bounds", h_out, 160'd0);
    hres = h_val(h_out);
    @(negedge clk);
    check(done === 1'b0, "R6 pulse", {159'd0, done}, 160'd0);
    check(msg_ready === 1'b0, "R1 idle", {159'd0, msg_ready}, 160'd0);
    // R7: idle hold with changed h_in
    begin
      logic [159:0] snap = h_out;
      h_in = ~h_in;
      repeat (3) @(negedge clk);
      check(h_out === snap, "R7 idle hold", h_out, snap);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [129:0] hcur;
    logic [129:0] rv;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && busy === 1'b0 && msg_ready === 1'b0 && h_out === '0,
          "R6 reset", h_out, 160'd0);
    rst_n = 1'b1;
    hcur = '0;
    for (int key = 0; key < 4; key++) begin
      case (key)
        0: rv = 130'h0_0000_0000_0000_0000_0000_0000_0000_0002;
        1: rv = 130'h0_0ffffffc_0ffffffc_0ffffffc_0fffffff;
        2: rv = {2'b00, $urandom(), $urandom(), $urandom(), $urandom()} & 130'h0_0ffffffc_0ffffffc_0ffffffc_0fffffff;
        default: rv = {130{1'b1}};
      endcase
      key_r1 = rv;
      key_r2 = mulmod(rv, rv);
      key_r3 = mulmod(key_r2, rv);
      key_r4 = mulmod(key_r3, rv);
      for (int pat = 0; pat < 3; pat++) begin
        for (int c = 0; c < 4; c++) begin
          case (pat)
            0: mbuf[c] = '0;
            1: mbuf[c] = '1;
            default: for (int w = 0; w < 16; w++) mbuf[c][32*w +: 32] = $urandom();
          endcase
        end
        for (int n = 0; n < 4; n++) begin
          run_op(hcur, n, 1'b1, (pat == 2 && n == 2), hcur);
          if (key == 1 && n == 3) run_op(hcur, 0, 1'b1, 1'b0, hcur);
        end
      end
    end
    // R8: every limb of every power at maximum, all-ones message
    key_r1 = {130{1'b1}}; key_r2 = {130{1'b1}}; key_r3 = {130{1'b1}}; key_r4 = {130{1'b1}};
    for (int c = 0; c < 4; c++) mbuf[c] = '1;
    run_op(pmod() - 130'd1, 3, 1'b0, 1'b0, hcur);
    run_op(hcur, 2, 1'b0, 1'b0, hcur);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule